// File: doc/BRIEF.md
# Buzzer Tone Generator with Decaying Envelope

The block makes a square-wave tone from its base clock, which is taken as the 32.768 kHz time base. Software picks one of eight divide ratios through a 3-bit field. The output has a 50% duty cycle for every ratio. A new ratio waits for the end of the current output period before it takes effect, so no short or stretched pulse reaches the pin.

An optional envelope makes the tone fade. While the envelope is on, an amplitude level falls from 7 (full) to 0 (silent) in equal time steps across a selectable half-second or one-second window. Writing the restart bit brings the level back to full. The amplitude is applied as a pulse-width gate on the tone, and the gate is also brought out on its own pin.

A true-and-complement pair drives the buzzer. The pin-enable input stands for the output-port latch that connects the tone to a pin.

Top module: `buzz_env_gen`

## Requirements
- R1: Frequency code k in 0..7 selects a divide ratio N of 8, 10, 12, 14, 16, 20, 24 or 28 respectively. With full amplitude, `buzz` rises every N clock cycles and stays high for N/2 of them.
- R2: After reset, `cfg_rdata` reads 0 (code 0, envelope off, short window), `env_level` is 7 and `buzz` is low.
- R3: A new frequency code is adopted only where the internal square wave rises. The period in progress when the write lands finishes at the old ratio, and the following period uses the new one.
- R4: A write with `cfg_we` stores `cfg_wdata[2:0]` as the frequency code, bit 3 as envelope enable (1 = on) and bit 4 as window select (1 = 1.0 s, 0 = 0.5 s). `cfg_rdata` returns these fields in the same positions. Bit 5 is the restart strobe and always reads 0.
- R5: With the envelope off, `env_level` holds 7 and the tone reaches the pins whenever `out_en` is high. With `out_en` low, both `buzz` and `buzz_n` stay low.
- R6: With the envelope on, `env_level` drops by one every STEP cycles. STEP is HALF_SEC_CYCLES/8 with the short window and HALF_SEC_CYCLES/4 with the long one. The level stops at 0.
- R7: A write with bit 5 set returns `env_level` to 7 on that clock edge and restarts the step timing.
- R8: `buzz_n` is high exactly when the gated tone is in its low half. The two outputs are never high together.
- R9: `pwm_out` is high for `env_level` cycles out of each 7-cycle frame. `buzz` and `buzz_n` are gated by it, so level 0 silences both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (time base) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 6 | Write data: [2:0] code, [3] envelope on, [4] long window, [5] restart |
| cfg_rdata | output | 6 | Register read-back, bit 5 reads 0 |
| out_en | input | 1 | Pin enable from the output latch |
| buzz | output | 1 | Tone output |
| buzz_n | output | 1 | Complementary tone output |
| env_level | output | 3 | Current amplitude level, 7 = full |
| pwm_out | output | 1 | Amplitude pulse-width gate |

## Verification
The block has no data stream, so every pin is a plain control pin and nothing applies back-pressure. The properties assume that the register write strobe is a single-cycle pulse taken at a clock edge. They also assume that reset is held long enough for every register to reach its cleared state. The stimulus drives `cfg_we` for exactly one cycle per write, between clock edges. It keeps `out_en` steady during each measurement window, so that period and duty results reflect only the divider and the envelope.

// File: rtl/bzr_pkg.sv
package bzr_pkg;
  localparam int SEL_W   = 3;
  localparam int LEVEL_W = 3;
  localparam int HALF_W  = 4;
  localparam logic [LEVEL_W-1:0] LEVEL_FULL = '1;

  // half of the divide ratio for each frequency code
  function automatic logic [HALF_W-1:0] half_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: half_ratio = 4'd4;
      3'd1: half_ratio = 4'd5;
      3'd2: half_ratio = 4'd6;
      3'd3: half_ratio = 4'd7;
      3'd4: half_ratio = 4'd8;
      3'd5: half_ratio = 4'd10;
      3'd6: half_ratio = 4'd12;
      default: half_ratio = 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/bzr_divider.sv
module bzr_divider
  import bzr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] req_sel,
  output logic [SEL_W-1:0] act_sel,
  output logic             sq
);
  logic [HALF_W-1:0] cnt;
  logic              wrap;

  assign wrap = (cnt == half_ratio(act_sel) - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      sq      <= 1'b0;
      act_sel <= '0;
    end else if (wrap) begin
      cnt <= '0;
      sq  <= ~sq;
      // a new period begins at the rising edge: adopt the pending code
      if (!sq) act_sel <= req_sel;
    end else begin
      cnt <= cnt + 4'd1;
    end
  end
endmodule

// File: rtl/bzr_envelope.sv
module bzr_envelope
  import bzr_pkg::*;
#(
  parameter int HALF_SEC_CYCLES = 16384
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               env_en,
  input  logic               env_slow,
  input  logic               restart,
  output logic [LEVEL_W-1:0] level
);
  localparam int STEP_SHORT = HALF_SEC_CYCLES / 8;
  localparam int STEP_LONG  = HALF_SEC_CYCLES / 4;
  localparam int TW         = $clog2(STEP_LONG);

  logic [TW-1:0] tcnt;
  logic [TW-1:0] step_last;

  assign step_last = env_slow ? TW'(STEP_LONG - 1) : TW'(STEP_SHORT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || !env_en || restart) begin
      level <= LEVEL_FULL;
      tcnt  <= '0;
    end else if (level != '0) begin
      if (tcnt >= step_last) begin
        tcnt  <= '0;
        level <= level - 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bzr_pwm.sv
module bzr_pwm
  import bzr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] level,
  output logic               gate
);
  localparam logic [LEVEL_W-1:0] FRAME_LAST = LEVEL_FULL - 1'b1;

  logic [LEVEL_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  pcnt <= '0;
    else if (pcnt == FRAME_LAST) pcnt <= '0;
    else                         pcnt <= pcnt + 1'b1;
  end

  assign gate = (pcnt < level);
endmodule

// File: rtl/buzz_env_gen.sv
module buzz_env_gen
  import bzr_pkg::*;
#(
  parameter int HALF_SEC_CYCLES = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [5:0] cfg_wdata,
  output logic [5:0] cfg_rdata,
  input  logic       out_en,
  output logic       buzz,
  output logic       buzz_n,
  output logic [2:0] env_level,
  output logic       pwm_out
);
  logic [SEL_W-1:0] freq_q;
  logic             env_en_q;
  logic             env_slow_q;
  logic             restart;
  logic [SEL_W-1:0] act_sel;
  logic             sq;
  logic             gate;

  assign restart = cfg_we & cfg_wdata[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q     <= '0;
      env_en_q   <= 1'b0;
      env_slow_q <= 1'b0;
    end else if (cfg_we) begin
      freq_q     <= cfg_wdata[2:0];
      env_en_q   <= cfg_wdata[3];
      env_slow_q <= cfg_wdata[4];
    end
  end

  assign cfg_rdata = {1'b0, env_slow_q, env_en_q, freq_q};

  bzr_divider u_div (
    .clk(clk), .rst_n(rst_n), .req_sel(freq_q), .act_sel(act_sel), .sq(sq)
  );

  bzr_envelope #(.HALF_SEC_CYCLES(HALF_SEC_CYCLES)) u_env (
    .clk(clk), .rst_n(rst_n), .env_en(env_en_q), .env_slow(env_slow_q),
    .restart(restart), .level(env_level)
  );

  bzr_pwm u_pwm (
    .clk(clk), .rst_n(rst_n), .level(env_level), .gate(gate)
  );

  assign pwm_out = gate;
  assign buzz    = out_en & gate & sq;
  assign buzz_n  = out_en & gate & ~sq;
endmodule

// File: rtl/buzz_env_gen_chk.sv
module buzz_env_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [5:0] cfg_wdata,
  input logic       env_en_q,
  input logic [2:0] act_sel,
  input logic       sq,
  input logic [2:0] env_level,
  input logic       buzz,
  input logic       buzz_n
);
  // R3
  sel_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_sel) |-> $rose(sq));

  // R6
  level_no_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (env_en_q && !(cfg_we && cfg_wdata[5])) |=> (env_level <= $past(env_level)));

  // R5
  env_off_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !env_en_q |=> (env_level == 3'd7));

  // R8
  pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(buzz && buzz_n));

  // R9
  silent_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (env_level == 3'd0) |-> (!buzz && !buzz_n));
endmodule

bind buzz_env_gen buzz_env_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .env_en_q(env_en_q), .act_sel(act_sel), .sq(sq), .env_level(env_level),
  .buzz(buzz), .buzz_n(buzz_n)
);

// File: tb/buzz_env_gen_tb.sv
`timescale 1ns/1ps
module buzz_env_gen_tb;
  localparam int HS   = 448;
  localparam int STEP_S = HS / 8;
  localparam int STEP_L = HS / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] cfg_rdata;
  logic       out_en = 1'b0;
  logic       buzz, buzz_n, pwm_out;
  logic [2:0] env_level;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  bit have_start = 0;
  bit done = 0;

  always #10 clk = ~clk;

  buzz_env_gen #(.HALF_SEC_CYCLES(HS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .out_en(out_en), .buzz(buzz), .buzz_n(buzz_n),
    .env_level(env_level), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int k);
    int t[8] = '{8, 10, 12, 14, 16, 20, 24, 28};
    return t[k];
  endfunction

  task automatic wr(input logic [5:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic wait_sb();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: measures rise-to-rise intervals and the high time of buzz
  initial begin
    bit prev = 0;
    int cnt = 0;
    int hi = 0;
    forever begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        have_start = 0;
      end else if (buzz && !prev) begin
        if (have_start) begin
          check("R1 period", cnt, exp_q[0]);
          check("R1 high time", hi, exp_q[0] / 2);
          void'(exp_q.pop_front());
        end
        have_start = (exp_q.size() != 0);
        cnt = 0; hi = 0;
      end
      cnt++;
      if (buzz) hi++;
      prev = buzz;
    end
  end

  initial begin
    #(150000 * 20);
    if (!done) begin
      n_fail++;
      $display("[TB] FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hcnt, n;
    repeat (4) @(negedge clk);
    // R2 reset state
    check("R2 rdata", cfg_rdata, 0);
    check("R2 level", env_level, 7);
    check("R2 buzz", buzz, 0);
    rst_n = 1'b1;
    // R4 field read-back, restart bit reads 0
    wr(6'b111101);
    check("R4 rdata", cfg_rdata, 6'b011101);
    wr(6'b000000);
    check("R4 rdata clear", cfg_rdata, 0);
    // R1 all frequency codes through the scoreboard, envelope off
    out_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      wr(6'(k));
      repeat (70) @(negedge clk);
      exp_q.push_back(ratio(k));
      exp_q.push_back(ratio(k));
      wait_sb();
    end
    // R3 code change mid-period: old period completes, then new one
    wr(6'd0);
    repeat (40) @(negedge clk);
    exp_q.push_back(8);
    exp_q.push_back(28);
    while (!have_start) @(negedge clk);
    wr(6'd7);
    wait_sb();
    check("R3 adopted", cfg_rdata[2:0], 7);
    // R8 complement while enabled
    wr(6'd1);
    repeat (30) @(negedge clk);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (buzz_n != !buzz) n++;
    end
    check("R8 complement mismatches", n, 0);
    // R5 out_en low keeps both pins low
    out_en = 1'b0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (buzz || buzz_n) n++;
    end
    check("R5 disabled pins high count", n, 0);
    check("R5 level with envelope off", env_level, 7);
    out_en = 1'b1;
    // R6 short window step timing
    wr(6'b101001);
    n = 0;
    while (env_level == 7 && n < 1000) begin @(negedge clk); n++; end
    check("R6 short step", n, STEP_S);
    // R9 pwm duty at level 6
    hcnt = 0;
    for (int i = 0; i < 7; i++) begin
      if (pwm_out) hcnt++;
      @(negedge clk);
    end
    check("R9 pwm high per frame", hcnt, 6);
    repeat (7 * STEP_S) @(negedge clk);
    check("R6 floor level", env_level, 0);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (buzz || buzz_n || pwm_out) n++;
    end
    check("R9 silent at level 0", n, 0);
    // R7 restart returns to full and restarts timing (long window)
    wr(6'b111001);
    check("R7 level after restart", env_level, 7);
    n = 0;
    while (env_level == 7 && n < 1000) begin @(negedge clk); n++; end
    check("R6 long step", n, STEP_L);
    repeat (STEP_L / 2) @(negedge clk);
    wr(6'b111001);
    check("R7 mid-decay restart", env_level, 7);
    n = 0;
    while (env_level == 7 && n < 1000) begin @(negedge clk); n++; end
    check("R7 step timing restarted", n, STEP_L);
    // R5 turning envelope off restores full level
    wr(6'b000001);
    @(negedge clk);
    check("R5 level after envelope off", env_level, 7);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule